// File: doc/BRIEF.md
# Memory-Mapped Register Bank with Atomic Vector Ports

This block sits between a processor's AXI4-Lite port and an algorithm core. It gives the core a set of scalar control words that software writes, a set of scalar status words that software reads, one input vector and one output vector. Each of these items has its own 32-bit word in a flat map with a stride of four bytes.

The input vector is double-buffered. Software first fills a staging word for each element. Writing the value one to the vector's trigger word then copies every staged element into the shadow copy that drives the core, so all elements change on the same edge. The output vector works the other way round. Writing one to its trigger word freezes every core output element into a snapshot, and later reads return that snapshot unchanged.

Readback of software-written words can be switched on or off at build time. The read multiplexer is split into segments of a configurable size, and each segment has its own pipeline register. This shortens the select path at the cost of one cycle of read latency.

Top module: `regbank_axil`

## Requirements
- R1: Word index = address bits [ADDR_W-1:2]; address bits [1:0] are ignored. The map, with V = VEC_LEN, is: scalar write words at 0..N_SIN-1; input staging elements at N_SIN..N_SIN+V-1; the input trigger word follows; then scalar read words (N_SOUT of them); then output snapshot elements (V); then the output trigger word. Total NREG = N_SIN+N_SOUT+2V+2.
- R2: Write address and write data are accepted in either order or together. bvalid rises only after both have been accepted, stays high until bready, and bresp is always 2'b00.
- R3: Each set bit i of the 4-bit write strobe replaces byte i (bits 8i+7..8i) of the target word; the other bytes keep their old value.
- R4: After reset, scalar write word k and staging/shadow element e hold INIT_SIN[32k+:32] and INIT_VIN[32e+:32]; snapshot elements hold zero.
- R5: Staging writes do not change core_vin. A write with wdata == 32'h1 and wstrb bit 0 set to the input trigger word copies all staged elements to core_vin on the edge that raises bvalid. Any other value written there changes nothing.
- R6: A write of 32'h1 (wstrb bit 0 set) to the output trigger word captures all core_vout elements on one edge. Snapshot reads return the captured values even after core_vout changes. Other trigger values capture nothing.
- R7: With READBACK=1, reading a scalar write word or a staging element returns its stored value. With READBACK=0 the read returns zero. Trigger words always read zero.
- R8: Reading a scalar read word returns the core_sout element present at the read.
- R9: Indices at or above NREG read as zero and ignore writes; both responses are OKAY (2'b00).
- R10: With one edge counted as the AR handshake, rvalid is seen after 2 edges when PIPE_RATIO=0 and after 3 edges otherwise. While rvalid waits for rready, rdata is stable and arready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response (always OKAY) |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response (always OKAY) |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| core_sin | output | N_SIN*32 | Scalar control words to the core |
| core_vin | output | VEC_LEN*32 | Shadowed input vector to the core |
| core_sout | input | N_SOUT*32 | Scalar status words from the core |
| core_vout | input | VEC_LEN*32 | Output vector from the core |

## Verification
The assertions assume a well-behaved manager. Once a valid is raised, it is held with stable address and data until its ready is seen. bready and rready may be held low for any length of time. The bench drives every channel from tasks that set valid on a falling edge and drop it only after the ready it saw there has been taken. Core outputs are only changed while no read is in flight. One stimulus stream drives two instances at once, one with readback and a pipelined multiplexer and one with neither, so that the timing and the data of both variants are checked against one arithmetic model.

// File: rtl/regbank_pkg.sv
// Shared constants and helpers for the register bank.
// Assumes a 32-bit data bus with four byte lanes.
package regbank_pkg;
    localparam int DATA_W = 32;
    localparam int STRB_W = DATA_W / 8;
    localparam logic [1:0] RESP_OKAY = 2'b00;

    // Replace the byte lanes selected by strb with those of nval.
    function automatic logic [DATA_W-1:0] byte_merge(
        input logic [DATA_W-1:0] oval,
        input logic [DATA_W-1:0] nval,
        input logic [STRB_W-1:0] strb
    );
        logic [DATA_W-1:0] r;
        r = oval;
        for (int b = 0; b < STRB_W; b++)
            if (strb[b]) r[b*8 +: 8] = nval[b*8 +: 8];
        return r;
    endfunction
endpackage

// File: rtl/regbank_wrchan.sv
// Write channel front end: accepts address and data independently,
// then issues a single-cycle commit and the write response.
// Assumes the manager holds valid signals until ready.
module regbank_wrchan
    import regbank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic              bvalid,
    input  logic              bready,
    output logic              commit,
    output logic [ADDR_W-1:0] c_addr,
    output logic [DATA_W-1:0] c_data,
    output logic [STRB_W-1:0] c_strb
);
    logic aw_held, w_held;

    assign awready = !aw_held;
    assign wready  = !w_held;
    assign commit  = aw_held && w_held && !bvalid;

    // Hold each half of the write until both are present, then respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aw_held <= 1'b0;
            w_held  <= 1'b0;
            bvalid  <= 1'b0;
            c_addr  <= '0;
            c_data  <= '0;
            c_strb  <= '0;
        end else begin
            if (awvalid && awready) begin
                aw_held <= 1'b1;
                c_addr  <= awaddr;
            end
            if (wvalid && wready) begin
                w_held <= 1'b1;
                c_data <= wdata;
                c_strb <= wstrb;
            end
            if (commit) begin
                aw_held <= 1'b0;
                w_held  <= 1'b0;
                bvalid  <= 1'b1;
            end else if (bvalid && bready) begin
                bvalid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/regbank_store.sv
// Register storage: scalar write words, input staging and shadow
// elements, output snapshot elements, and the flat readback image.
// Assumes commit is a one-cycle pulse from the write channel.
module regbank_store
    import regbank_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int N_SIN    = 2,
    parameter int N_SOUT   = 2,
    parameter int VEC_LEN  = 4,
    parameter bit READBACK = 1'b1,
    parameter logic [N_SIN*DATA_W-1:0]   INIT_SIN = '0,
    parameter logic [VEC_LEN*DATA_W-1:0] INIT_VIN = '0,
    localparam int I_VST  = N_SIN,
    localparam int I_VSTB = I_VST + VEC_LEN,
    localparam int I_SOUT = I_VSTB + 1,
    localparam int I_VOUT = I_SOUT + N_SOUT,
    localparam int I_VOSB = I_VOUT + VEC_LEN,
    localparam int NREG   = I_VOSB + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        commit,
    input  logic [ADDR_W-1:0]           c_addr,
    input  logic [DATA_W-1:0]           c_data,
    input  logic [STRB_W-1:0]           c_strb,
    input  logic [N_SOUT*DATA_W-1:0]    core_sout,
    input  logic [VEC_LEN*DATA_W-1:0]   core_vout,
    output logic [N_SIN*DATA_W-1:0]     core_sin,
    output logic [VEC_LEN*DATA_W-1:0]   core_vin,
    output logic [NREG*DATA_W-1:0]      rd_words,
    output logic                        vin_hit
);
    localparam int IW = ADDR_W - 2;

    logic [IW-1:0] c_idx;
    logic          trig_val, vout_hit;

    assign c_idx    = c_addr[ADDR_W-1:2];
    assign trig_val = c_strb[0] && (c_data == DATA_W'(1));
    assign vin_hit  = commit && (c_idx == IW'(I_VSTB)) && trig_val;
    assign vout_hit = commit && (c_idx == IW'(I_VOSB)) && trig_val;

    assign rd_words[I_VSTB*DATA_W +: DATA_W] = '0;
    assign rd_words[I_VOSB*DATA_W +: DATA_W] = '0;

    for (genvar k = 0; k < N_SIN; k++) begin : g_sin
        logic [DATA_W-1:0] q;
        // Scalar control word: byte-merged on a write to its index.
        always_ff @(posedge clk) begin
            if (!rst_n)                             q <= INIT_SIN[k*DATA_W +: DATA_W];
            else if (commit && c_idx == IW'(k))     q <= byte_merge(q, c_data, c_strb);
        end
        assign core_sin[k*DATA_W +: DATA_W] = q;
        assign rd_words[k*DATA_W +: DATA_W] = READBACK ? q : '0;
    end

    for (genvar e = 0; e < VEC_LEN; e++) begin : g_vec
        logic [DATA_W-1:0] stage_q, shadow_q, snap_q;
        // Staging element: written by software, invisible to the core.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   stage_q <= INIT_VIN[e*DATA_W +: DATA_W];
            else if (commit && c_idx == IW'(I_VST + e))   stage_q <= byte_merge(stage_q, c_data, c_strb);
        end
        // Shadow element: loaded from staging only on the input trigger.
        always_ff @(posedge clk) begin
            if (!rst_n)       shadow_q <= INIT_VIN[e*DATA_W +: DATA_W];
            else if (vin_hit) shadow_q <= stage_q;
        end
        // Snapshot element: samples the core output on the output trigger.
        always_ff @(posedge clk) begin
            if (!rst_n)        snap_q <= '0;
            else if (vout_hit) snap_q <= core_vout[e*DATA_W +: DATA_W];
        end
        assign core_vin[e*DATA_W +: DATA_W]            = shadow_q;
        assign rd_words[(I_VST+e)*DATA_W +: DATA_W]  = READBACK ? stage_q : '0;
        assign rd_words[(I_VOUT+e)*DATA_W +: DATA_W] = snap_q;
    end

    for (genvar o = 0; o < N_SOUT; o++) begin : g_sout
        assign rd_words[(I_SOUT+o)*DATA_W +: DATA_W] = core_sout[o*DATA_W +: DATA_W];
    end
endmodule

// File: rtl/regbank_rdpipe.sv
// Read channel with a segmented, optionally pipelined select tree.
// PIPE_RATIO=0 selects directly; otherwise one register per segment of
// PIPE_RATIO words (5..50) adds one cycle. One read is in flight at a time.
module regbank_rdpipe
    import regbank_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int NREG       = 14,
    parameter int PIPE_RATIO = 5,
    localparam int IW   = ADDR_W - 2,
    localparam int NSEG = (PIPE_RATIO == 0) ? 1 : (NREG + PIPE_RATIO - 1) / PIPE_RATIO,
    localparam int NPAD = (PIPE_RATIO == 0) ? NREG : NSEG * PIPE_RATIO
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      araddr,
    input  logic                   arvalid,
    output logic                   arready,
    output logic [DATA_W-1:0]      rdata,
    output logic                   rvalid,
    input  logic                   rready,
    input  logic [NREG*DATA_W-1:0] rd_words
);
    logic [DATA_W-1:0] wd [NPAD];
    logic              busy, s1_v, final_v;
    logic [IW-1:0]     idx_q;
    logic [DATA_W-1:0] final_word;

    for (genvar k = 0; k < NPAD; k++) begin : g_pad
        if (k < NREG) begin : g_real
            assign wd[k] = rd_words[k*DATA_W +: DATA_W];
        end else begin : g_zero
            assign wd[k] = '0;
        end
    end

    assign arready = !busy;

    // Accept one address, track the in-flight read, deliver the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            s1_v   <= 1'b0;
            idx_q  <= '0;
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            s1_v <= arvalid && !busy;
            if (arvalid && !busy) begin
                busy  <= 1'b1;
                idx_q <= araddr[ADDR_W-1:2];
            end
            if (final_v) begin
                rvalid <= 1'b1;
                rdata  <= final_word;
            end else if (rvalid && rready) begin
                rvalid <= 1'b0;
                busy   <= 1'b0;
            end
        end
    end

    if (PIPE_RATIO == 0) begin : g_flat
        assign final_v = s1_v;
        // Direct select across all words.
        always_comb begin
            final_word = '0;
            for (int k = 0; k < NPAD; k++)
                if (idx_q == IW'(k)) final_word = wd[k];
        end
    end else begin : g_seg
        logic [DATA_W-1:0] seg_q [NSEG];
        logic [IW-1:0]     sel_q;
        logic              s2_v;
        for (genvar s = 0; s < NSEG; s++) begin : g_s
            logic [DATA_W-1:0] pick;
            // Local select within one segment.
            always_comb begin
                pick = '0;
                for (int k = 0; k < PIPE_RATIO; k++)
                    if (idx_q == IW'(s*PIPE_RATIO + k)) pick = wd[s*PIPE_RATIO + k];
            end
            // Segment pipeline register.
            always_ff @(posedge clk) begin
                if (!rst_n)    seg_q[s] <= '0;
                else if (s1_v) seg_q[s] <= pick;
            end
        end
        // Second stage valid and segment number.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s2_v  <= 1'b0;
                sel_q <= '0;
            end else begin
                s2_v <= s1_v;
                if (s1_v) sel_q <= idx_q / IW'(PIPE_RATIO);
            end
        end
        assign final_v = s2_v;
        // Final select among segment registers.
        always_comb begin
            final_word = '0;
            for (int s = 0; s < NSEG; s++)
                if (sel_q == IW'(s)) final_word = seg_q[s];
        end
    end
endmodule

// File: rtl/regbank_axil.sv
// Top of the register bank: AXI4-Lite subordinate port, storage and
// pipelined readback. Assumes one clock domain and 4-byte word stride.
module regbank_axil
    import regbank_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int N_SIN      = 2,
    parameter int N_SOUT     = 2,
    parameter int VEC_LEN    = 4,
    parameter bit READBACK   = 1'b1,
    parameter int PIPE_RATIO = 5,
    parameter logic [N_SIN*32-1:0]   INIT_SIN = '0,
    parameter logic [VEC_LEN*32-1:0] INIT_VIN = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       s_awaddr,
    input  logic                    s_awvalid,
    output logic                    s_awready,
    input  logic [31:0]             s_wdata,
    input  logic [3:0]              s_wstrb,
    input  logic                    s_wvalid,
    output logic                    s_wready,
    output logic [1:0]              s_bresp,
    output logic                    s_bvalid,
    input  logic                    s_bready,
    input  logic [ADDR_W-1:0]       s_araddr,
    input  logic                    s_arvalid,
    output logic                    s_arready,
    output logic [31:0]             s_rdata,
    output logic [1:0]              s_rresp,
    output logic                    s_rvalid,
    input  logic                    s_rready,
    output logic [N_SIN*32-1:0]     core_sin,
    output logic [VEC_LEN*32-1:0]   core_vin,
    input  logic [N_SOUT*32-1:0]    core_sout,
    input  logic [VEC_LEN*32-1:0]   core_vout
);
    localparam int NREG = N_SIN + N_SOUT + 2*VEC_LEN + 2;

    logic                   wr_commit, vin_hit;
    logic [ADDR_W-1:0]      c_addr;
    logic [DATA_W-1:0]      c_data;
    logic [STRB_W-1:0]      c_strb;
    logic [NREG*DATA_W-1:0] rd_words;

    assign s_bresp = RESP_OKAY;
    assign s_rresp = RESP_OKAY;

    regbank_wrchan #(.ADDR_W(ADDR_W)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
        .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
        .bvalid(s_bvalid), .bready(s_bready),
        .commit(wr_commit), .c_addr(c_addr), .c_data(c_data), .c_strb(c_strb)
    );

    regbank_store #(
        .ADDR_W(ADDR_W), .N_SIN(N_SIN), .N_SOUT(N_SOUT), .VEC_LEN(VEC_LEN),
        .READBACK(READBACK), .INIT_SIN(INIT_SIN), .INIT_VIN(INIT_VIN)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .commit(wr_commit), .c_addr(c_addr), .c_data(c_data), .c_strb(c_strb),
        .core_sout(core_sout), .core_vout(core_vout),
        .core_sin(core_sin), .core_vin(core_vin),
        .rd_words(rd_words), .vin_hit(vin_hit)
    );

    regbank_rdpipe #(.ADDR_W(ADDR_W), .NREG(NREG), .PIPE_RATIO(PIPE_RATIO)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
        .rdata(s_rdata), .rvalid(s_rvalid), .rready(s_rready),
        .rd_words(rd_words)
    );
endmodule

// File: rtl/regbank_chk.sv
// Protocol and shadowing checks for regbank_axil, attached by bind.
// Assumes a manager that holds valid until ready.
module regbank_chk #(
    parameter int VEC_LEN = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bvalid,
    input logic                  bready,
    input logic [1:0]            bresp,
    input logic                  rvalid,
    input logic                  rready,
    input logic [1:0]            rresp,
    input logic [31:0]           rdata,
    input logic                  arready,
    input logic [VEC_LEN*32-1:0] core_vin,
    input logic                  vin_hit,
    input logic                  commit
);
    p_bresp_okay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid |-> bresp == 2'b00);
    p_bvalid_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && !bready |=> bvalid);
    p_bvalid_after_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bvalid) |-> $past(commit));
    p_vin_only_on_trigger_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !vin_hit |=> $stable(core_vin));
    p_rresp_okay_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> rresp == 2'b00);
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && !rready |=> rvalid && $stable(rdata));
    p_single_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> !arready);
endmodule

bind regbank_axil regbank_chk #(.VEC_LEN(VEC_LEN)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
    .rvalid(s_rvalid), .rready(s_rready), .rresp(s_rresp), .rdata(s_rdata),
    .arready(s_arready), .core_vin(core_vin),
    .vin_hit(vin_hit), .commit(wr_commit)
);

// File: tb/sim_regbank_axil.sv
// Drives two instances from one stimulus: u0 (readback on, segmented
// select) and u1 (readback off, direct select), checked against a model.
module sim_regbank_axil;
    localparam int NS = 2, NO = 2, VL = 3;
    localparam int I_VST = 2, I_VSTB = 5, I_SOUT = 6, I_VOUT = 8, I_VOSB = 11;

    logic clk = 1'b0, rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [7:0]  awaddr = '0, araddr = '0;
    logic        awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        bready = 1'b1, rready0 = 1'b1, rready1 = 1'b1;
    logic [NO*32-1:0] sout = {32'hC3C3_0002, 32'h5A5A_0001};
    logic [VL*32-1:0] vout = {32'h0000_0030, 32'h0000_0020, 32'h0000_0010};

    logic        awready0, wready0, bvalid0, arready0, rvalid0;
    logic        awready1, wready1, bvalid1, arready1, rvalid1;
    logic [1:0]  bresp0, rresp0, bresp1, rresp1;
    logic [31:0] rdata0, rdata1;
    logic [NS*32-1:0] sin0, sin1;
    logic [VL*32-1:0] vin0, vin1;

    regbank_axil #(.ADDR_W(8), .N_SIN(NS), .N_SOUT(NO), .VEC_LEN(VL),
        .READBACK(1'b1), .PIPE_RATIO(5),
        .INIT_SIN({32'h0, 32'h0000_00A5}),
        .INIT_VIN({32'd3, 32'd2, 32'd1})) u0 (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready0),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready0),
        .s_bresp(bresp0), .s_bvalid(bvalid0), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready0),
        .s_rdata(rdata0), .s_rresp(rresp0), .s_rvalid(rvalid0), .s_rready(rready0),
        .core_sin(sin0), .core_vin(vin0), .core_sout(sout), .core_vout(vout));

    regbank_axil #(.ADDR_W(8), .N_SIN(NS), .N_SOUT(NO), .VEC_LEN(VL),
        .READBACK(1'b0), .PIPE_RATIO(0)) u1 (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready1),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready1),
        .s_bresp(bresp1), .s_bvalid(bvalid1), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready1),
        .s_rdata(rdata1), .s_rresp(rresp1), .s_rvalid(rvalid1), .s_rready(rready1),
        .core_sin(sin1), .core_vin(vin1), .core_sout(sout), .core_vout(vout));

    int checks = 0, fails = 0;
    logic [31:0] m_sin0 [NS] = '{32'hA5, 32'h0};
    logic [31:0] m_sin1 [NS] = '{32'h0, 32'h0};
    logic [31:0] m_vst0 [VL] = '{32'd1, 32'd2, 32'd3};
    logic [31:0] m_vst1 [VL] = '{32'd0, 32'd0, 32'd0};
    logic [31:0] m_vin0 [VL] = '{32'd1, 32'd2, 32'd3};
    logic [31:0] m_vin1 [VL] = '{32'd0, 32'd0, 32'd0};
    logic [31:0] m_snap [VL] = '{32'd0, 32'd0, 32'd0};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] s);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (s[b]) r[b*8 +: 8] = n[b*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] exp_rd(input int idx, input bit rb);
        if (idx < I_VST)  return rb ? m_sin0[idx] : 32'h0;
        if (idx < I_VSTB) return rb ? m_vst0[idx-I_VST] : 32'h0;
        if (idx < I_SOUT) return 32'h0;
        if (idx < I_VOUT) return sout[(idx-I_SOUT)*32 +: 32];
        if (idx < I_VOSB) return m_snap[idx-I_VOUT];
        return 32'h0;
    endfunction

    // Compare core-facing outputs of both instances with the model.
    task automatic core_chk(input string req);
        for (int k = 0; k < NS; k++) begin
            chk(req, sin0[k*32 +: 32], m_sin0[k]);
            chk(req, sin1[k*32 +: 32], m_sin1[k]);
        end
        for (int e = 0; e < VL; e++) begin
            chk(req, vin0[e*32 +: 32], m_vin0[e]);
            chk(req, vin1[e*32 +: 32], m_vin1[e]);
        end
    endtask

    // Wait for pending address/data handshakes, dropping valid after each.
    task automatic hs_wait();
        while (awvalid || wvalid) begin
            logic ga, gw;
            ga = awvalid && awready0;
            gw = wvalid && wready0;
            @(negedge clk);
            if (ga) awvalid = 1'b0;
            if (gw) wvalid = 1'b0;
        end
    endtask

    // ord 0: together, 1: address first, 2: data first.
    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s, input int ord);
        int idx;
        @(negedge clk);
        if (ord != 2) begin awaddr = a; awvalid = 1'b1; end
        if (ord != 1) begin wdata = d; wstrb = s; wvalid = 1'b1; end
        hs_wait();
        if (ord != 0) begin
            repeat (2) @(negedge clk);
            chk("R2 no response with one half", {31'b0, bvalid0 | bvalid1}, 32'h0);
            if (ord == 1) begin wdata = d; wstrb = s; wvalid = 1'b1; end
            else begin awaddr = a; awvalid = 1'b1; end
            hs_wait();
        end
        while (!bvalid0) @(negedge clk);
        chk("R2 bresp okay", {28'b0, bresp0, bresp1}, 32'h0);
        chk("R2 both respond", {31'b0, bvalid1}, 32'h1);
        idx = int'(a[7:2]);
        if (idx < I_VST) begin
            m_sin0[idx] = merge(m_sin0[idx], d, s);
            m_sin1[idx] = merge(m_sin1[idx], d, s);
        end else if (idx < I_VSTB) begin
            m_vst0[idx-I_VST] = merge(m_vst0[idx-I_VST], d, s);
            m_vst1[idx-I_VST] = merge(m_vst1[idx-I_VST], d, s);
        end else if (idx == I_VSTB && s[0] && d == 32'h1) begin
            m_vin0 = m_vst0;
            m_vin1 = m_vst1;
        end else if (idx == I_VOSB && s[0] && d == 32'h1) begin
            for (int e = 0; e < VL; e++) m_snap[e] = vout[e*32 +: 32];
        end
        @(negedge clk);
    endtask

    // Read from both instances; latency counted in edges from the AR handshake.
    task automatic rd(input logic [7:0] a, output logic [31:0] d0, output logic [31:0] d1,
                      output int l0, output int l1);
        @(negedge clk);
        araddr = a; arvalid = 1'b1;
        while (!(arready0 && arready1)) @(negedge clk);
        @(negedge clk);
        arvalid = 1'b0;
        l0 = -1; l1 = -1; d0 = '0; d1 = '0;
        for (int c = 1; c < 10 && (l0 < 0 || l1 < 0); c++) begin
            if (l0 < 0 && rvalid0) begin
                l0 = c; d0 = rdata0;
                chk("R9 rresp okay", {30'b0, rresp0}, 32'h0);
            end
            if (l1 < 0 && rvalid1) begin l1 = c; d1 = rdata1; end
            if (l0 < 0 || l1 < 0) @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic rd_chk(input logic [7:0] a, input string req);
        logic [31:0] d0, d1;
        int l0, l1;
        rd(a, d0, d1, l0, l1);
        chk({req, " u0 data"}, d0, exp_rd(int'(a[7:2]), 1'b1));
        chk({req, " u1 data"}, d1, exp_rd(int'(a[7:2]), 1'b0));
        chk("R10 latency segmented", l0, 32'd3);
        chk("R10 latency direct", l1, 32'd2);
    endtask

    // Full sweep over every word index of the 8-bit address space.
    task automatic sweep(input string req);
        for (int i = 0; i < 64; i++) rd_chk(8'(i*4), req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: reset contents on the core side and idle channels.
        core_chk("R4 reset values");
        chk("R4 idle after reset", {28'b0, bvalid0, rvalid0, arready0, awready0}, 32'h3);

        // R4 R7 R8 R9 R10 R6: full map sweep in reset state (snapshot zero).
        sweep("R7 R9 reset sweep");

        // R2: all three arrival orders.
        wr(8'h00, 32'h1111_1111, 4'hF, 0);
        wr(8'h04, 32'h2222_2222, 4'hF, 1);
        wr(8'h08, 32'h0000_0AAA, 4'hF, 2);
        core_chk("R2 write orders");
        rd_chk(8'h00, "R7 readback");
        rd_chk(8'h04, "R7 readback");

        // R3: byte lanes 0 and 2 only.
        wr(8'h04, 32'hAABB_CCDD, 4'b0101, 0);
        chk("R3 byte merge", sin1[32 +: 32], 32'h22BB_22DD);
        core_chk("R3 byte merge");
        wr(8'h00, 32'hFFFF_FFFF, 4'b1000, 1);
        core_chk("R3 top lane");
        rd_chk(8'h04, "R3 readback");

        // R5: partial staging update is not seen until the trigger.
        wr(8'h08, 32'h0000_0100, 4'hF, 0);
        wr(8'h10, 32'h0000_0300, 4'hF, 2);
        core_chk("R5 staged not visible");
        wr(8'h14, 32'h0000_0002, 4'hF, 0);
        core_chk("R5 trigger value 2 ignored");
        wr(8'h14, 32'h0000_0001, 4'b0001, 1);
        chk("R5 element 0 updated", vin0[0 +: 32], 32'h0000_0100);
        chk("R5 element 2 updated", vin0[64 +: 32], 32'h0000_0300);
        core_chk("R5 atomic update");
        rd_chk(8'h14, "R7 trigger reads zero");

        // R8: live scalar status values.
        @(negedge clk); sout = {32'h1234_5678, 32'h9ABC_DEF0};
        rd_chk(8'h18, "R8 live status");
        rd_chk(8'h1C, "R8 live status");

        // R6: capture, then change core outputs; snapshot must hold.
        wr(8'h2C, 32'h0000_0001, 4'hF, 0);
        @(negedge clk); vout = {32'hDEAD_0003, 32'hDEAD_0002, 32'hDEAD_0001};
        for (int e = 0; e < VL; e++) rd_chk(8'(32 + 4*e), "R6 snapshot held");
        wr(8'h2C, 32'h0000_0003, 4'hF, 0);
        for (int e = 0; e < VL; e++) rd_chk(8'(32 + 4*e), "R6 trigger value 3 ignored");
        wr(8'h2C, 32'h0000_0001, 4'hF, 2);
        rd_chk(8'h24, "R6 recapture");

        // R9: writes outside the map change nothing.
        wr(8'h30, 32'hFFFF_FFFF, 4'hF, 0);
        wr(8'hFC, 32'hFFFF_FFFF, 4'hF, 1);
        core_chk("R9 unmapped write ignored");

        // R1: low address bits ignored on reads.
        begin
            logic [31:0] d0, d1;
            int l0, l1;
            rd(8'h03, d0, d1, l0, l1);
            chk("R1 low bits ignored", d0, m_sin0[0]);
            rd(8'h0A, d0, d1, l0, l1);
            chk("R1 staging index", d0, m_vst0[0]);
        end

        // R10: hold read data while rready is low.
        @(negedge clk);
        rready0 = 1'b0; araddr = 8'h00; arvalid = 1'b1;
        while (!arready0) @(negedge clk);
        @(negedge clk); arvalid = 1'b0;
        while (!rvalid0) @(negedge clk);
        repeat (3) begin
            @(negedge clk);
            chk("R10 rvalid held", {31'b0, rvalid0}, 32'h1);
            chk("R10 arready low while pending", {31'b0, arready0}, 32'h0);
            chk("R10 rdata stable", rdata0, m_sin0[0]);
        end
        rready0 = 1'b1;
        @(negedge clk);
        chk("R10 released", {30'b0, rvalid0, arready0}, 32'h1);

        sweep("R7 R9 final sweep");
        core_chk("R5 final core state");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule